// File: doc/BRIEF.md
# Handshaked Bus Access Sequencer

This block is the bus master of a small controller-style processor. The core hands it one access at a time: a memory access with a flat word address, or an external-register access that names a bank and a register within that bank. The block turns each access into one bus cycle. Address and data have their own lines and are never multiplexed.

Memory and external registers each have their own request/done handshake pair. The handshake is fully interlocked. The request stays high until the slave's done line is seen high, then it falls. The block stays busy until done has gone low again, so a slow slave stretches the access for as long as it needs. Done inputs are asynchronous and pass through a synchronizer. Read data is latched on the edge that first sees the synchronized done high.

All bus outputs come straight from registers and stay static for the whole access, so the system can be single-stepped one clock at a time. Once an access is accepted, new core requests are ignored until the sequencer is idle again.

Top module: `bus_seq`

## Requirements
- R1: While reset is low and just after it is released, busy is 0, both request lines are 0, the idle flag is 1, the read flag is 1, the fetch flag is 0 and the read-data holding register is 0.
- R2: A core request sampled while idle raises busy and exactly one request line in the next cycle: the I/O request line when the kind input is 1, the memory request line when it is 0. The two request lines are never high together.
- R3: The memory address output equals the requested memory address. The external-register address output is the bank number in bits 10:3 and the register index in bits 2:0.
- R4: The memory address, external-register address, write data, read flag (1 = read, 0 = write) and fetch flag stay unchanged from the cycle the request line rises until busy falls.
- R5: The request line stays high for any number of cycles until the matching done line has been seen high through the two-stage synchronizer. There is no timeout.
- R6: A read access loads the bus read data into the holding register three clock edges after done rises. A one-cycle completion pulse is high in that same cycle, and the request line falls in that cycle.
- R7: A write access leaves the holding register unchanged.
- R8: After the request falls, busy stays high and no request is raised until done has been low for three clock edges. Busy then falls and idle rises.
- R9: Core requests presented while busy are ignored. They change no bus output and start no new access.
- R10: The done line of the other access kind is ignored. It neither completes nor shortens the current access.
- R11: The fetch flag follows the fetch bit of the accepted request. The idle flag is the inverse of busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single-phase system clock |
| rst_n | input | 1 | Power-on reset, active low |
| core_valid | input | 1 | Core access request, sampled while idle |
| core_io | input | 1 | 1 = external-register access, 0 = memory access |
| core_write | input | 1 | 1 = write, 0 = read |
| core_fetch | input | 1 | Access is an instruction fetch |
| core_maddr | input | 16 | Memory word address |
| core_bank | input | 8 | External-register bank number |
| core_idx | input | 3 | Register index within the bank |
| core_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| cmpl | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read-data holding register |
| bus_maddr | output | 16 | Memory address lines |
| bus_xaddr | output | 11 | External-register address {bank, index} |
| bus_wdata | output | 16 | Write data lines |
| bus_rd | output | 1 | 1 = read, 0 = write |
| bus_fetch | output | 1 | Instruction-fetch indicator |
| bus_idle | output | 1 | Idle indicator |
| mem_req | output | 1 | Memory request |
| mem_done | input | 1 | Memory done, asynchronous |
| io_req | output | 1 | External-register request |
| io_done | input | 1 | External-register done, asynchronous |
| bus_rdata | input | 16 | Read data lines |

## Verification
Some properties are checked on every cycle of every access:
- the two request lines are never high together;
- a request holds until the synchronized done is seen;
- the request drops after completion and is not raised again during the release phase;
- the bus outputs stay static while busy.

Other behaviour only the bench scenarios can show:
- the exact three-edge latency on done rising and on done falling;
- the {bank, index} address layout over every index and several banks;
- that read data lands in the holding register and that writes leave it alone;
- that stray done pulses and requests made while busy change nothing at the ports.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int BANK_W = 8;
  localparam int IDX_W  = 3;
  localparam int XA_W   = BANK_W + IDX_W;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_HOLD    = 2'd1,
    ST_RELEASE = 2'd2
  } bseq_state_e;

  // external-register address: bank in the high bits, in-bank index low
  function automatic logic [XA_W-1:0] form_xaddr(input logic [BANK_W-1:0] bank,
                                                  input logic [IDX_W-1:0]  idx);
    return {bank, idx};
  endfunction
endpackage

// File: rtl/bseq_sync.sv
module bseq_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic core_valid,
  input  logic core_io,
  input  logic core_write,
  input  logic done_mem_s,
  input  logic done_io_s,
  output logic accept,
  output logic cap_rd,
  output logic cmpl,
  output logic mem_req,
  output logic io_req,
  output logic busy
);
  bseq_state_e st_q, st_d;
  logic kind_io_q, wr_q;
  logic done_sel, finish, release_end;

  assign accept      = (st_q == ST_IDLE) && core_valid;
  assign done_sel    = kind_io_q ? done_io_s : done_mem_s;
  assign finish      = (st_q == ST_HOLD) && done_sel;
  assign release_end = (st_q == ST_RELEASE) && !done_sel;
  assign cap_rd      = finish && !wr_q;
  assign busy        = (st_q != ST_IDLE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (accept)      st_d = ST_HOLD;
      ST_HOLD:    if (finish)      st_d = ST_RELEASE;
      ST_RELEASE: if (release_end) st_d = ST_IDLE;
      default:                     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      kind_io_q <= 1'b0;
      wr_q      <= 1'b0;
      mem_req   <= 1'b0;
      io_req    <= 1'b0;
      cmpl      <= 1'b0;
    end else begin
      st_q <= st_d;
      cmpl <= finish;
      if (accept) begin
        kind_io_q <= core_io;
        wr_q      <= core_write;
        mem_req   <= !core_io;
        io_req    <= core_io;
      end else if (finish) begin
        mem_req <= 1'b0;
        io_req  <= 1'b0;
      end
    end
  end

  AST_ONE_REQ_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && io_req)); // R2
  AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || io_req) |-> busy); // R2
  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_HOLD) && !done_sel) |=> (mem_req || io_req)); // R5
  AST_DROP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !(mem_req || io_req)); // R8
  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RELEASE) |-> !(mem_req || io_req)); // R8
endmodule

// File: rtl/bseq_regs.sv
module bseq_regs
  import bseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              cap_rd,
  input  logic              busy,
  input  logic              core_write,
  input  logic              core_fetch,
  input  logic [AW-1:0]     core_maddr,
  input  logic [BANK_W-1:0] core_bank,
  input  logic [IDX_W-1:0]  core_idx,
  input  logic [DW-1:0]     core_wdata,
  input  logic [DW-1:0]     bus_rdata,
  output logic [AW-1:0]     bus_maddr,
  output logic [XA_W-1:0]   bus_xaddr,
  output logic [DW-1:0]     bus_wdata,
  output logic              bus_rd,
  output logic              bus_fetch,
  output logic [DW-1:0]     rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_maddr <= '0;
      bus_xaddr <= '0;
      bus_wdata <= '0;
      bus_rd    <= 1'b1;
      bus_fetch <= 1'b0;
    end else if (accept) begin
      bus_maddr <= core_maddr;
      bus_xaddr <= form_xaddr(core_bank, core_idx);
      bus_wdata <= core_wdata;
      bus_rd    <= !core_write;
      bus_fetch <= core_fetch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (cap_rd) rd_data <= bus_rdata;
  end

  AST_STATIC_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(bus_maddr) && $stable(bus_xaddr) &&
      $stable(bus_wdata) && $stable(bus_rd) && $stable(bus_fetch))); // R4
endmodule

// File: rtl/bus_seq.sv
module bus_seq
  import bseq_pkg::*;
#(
  parameter int MEM_AW      = 16,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_valid,
  input  logic              core_io,
  input  logic              core_write,
  input  logic              core_fetch,
  input  logic [MEM_AW-1:0] core_maddr,
  input  logic [BANK_W-1:0] core_bank,
  input  logic [IDX_W-1:0]  core_idx,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              busy,
  output logic              cmpl,
  output logic [DATA_W-1:0] rd_data,
  output logic [MEM_AW-1:0] bus_maddr,
  output logic [XA_W-1:0]   bus_xaddr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rd,
  output logic              bus_fetch,
  output logic              bus_idle,
  output logic              mem_req,
  input  logic              mem_done,
  output logic              io_req,
  input  logic              io_done,
  input  logic [DATA_W-1:0] bus_rdata
);
  logic [1:0] done_raw, done_s;
  logic accept, cap_rd;

  assign done_raw = {io_done, mem_done};

  bseq_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(done_raw), .q(done_s)
  );

  bseq_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .core_valid(core_valid), .core_io(core_io), .core_write(core_write),
    .done_mem_s(done_s[0]), .done_io_s(done_s[1]),
    .accept(accept), .cap_rd(cap_rd), .cmpl(cmpl),
    .mem_req(mem_req), .io_req(io_req), .busy(busy)
  );

  bseq_regs #(.AW(MEM_AW), .DW(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .accept(accept), .cap_rd(cap_rd), .busy(busy),
    .core_write(core_write), .core_fetch(core_fetch),
    .core_maddr(core_maddr), .core_bank(core_bank), .core_idx(core_idx),
    .core_wdata(core_wdata), .bus_rdata(bus_rdata),
    .bus_maddr(bus_maddr), .bus_xaddr(bus_xaddr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_fetch(bus_fetch), .rd_data(rd_data)
  );

  assign bus_idle = !busy;

  AST_IDLE_MATCHES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle != busy); // R11
endmodule

// File: tb/bus_seq_tb_top.sv
`timescale 1ns/1ps
module bus_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_valid = 0, core_io = 0, core_write = 0, core_fetch = 0;
  logic [15:0] core_maddr = '0;
  logic [7:0]  core_bank = '0;
  logic [2:0]  core_idx = '0;
  logic [15:0] core_wdata = '0;
  logic busy, cmpl, bus_rd, bus_fetch, bus_idle, mem_req, io_req;
  logic [15:0] rd_data, bus_maddr, bus_wdata;
  logic [10:0] bus_xaddr;
  logic mem_done = 0, io_done = 0;
  logic [15:0] bus_rdata = '0;

  int total = 0, bad = 0;
  logic [15:0] exp_rd = '0;
  bit finished = 0;

  always #4 clk = ~clk;

  bus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .core_valid(core_valid), .core_io(core_io),
    .core_write(core_write), .core_fetch(core_fetch), .core_maddr(core_maddr),
    .core_bank(core_bank), .core_idx(core_idx), .core_wdata(core_wdata),
    .busy(busy), .cmpl(cmpl), .rd_data(rd_data), .bus_maddr(bus_maddr),
    .bus_xaddr(bus_xaddr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_fetch(bus_fetch), .bus_idle(bus_idle), .mem_req(mem_req),
    .mem_done(mem_done), .io_req(io_req), .io_done(io_done), .bus_rdata(bus_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_bus(input bit io, input bit wr, input bit fe,
                         input logic [15:0] ma, input logic [7:0] bk,
                         input logic [2:0] ix, input logic [15:0] wd, input string ph);
    logic [10:0] xa;
    xa = {bk, ix};
    chk(busy === 1'b1, {"R2 busy ", ph}, busy, 1);
    chk(io_req === io && mem_req === !io, {"R2 req line ", ph}, {io_req, mem_req}, {io, !io});
    chk(bus_idle === 1'b0, {"R11 idle ", ph}, bus_idle, 0);
    chk(bus_fetch === fe, {"R11 fetch ", ph}, bus_fetch, fe);
    if (io) chk(bus_xaddr === xa, {"R3 xaddr ", ph}, bus_xaddr, xa);
    else    chk(bus_maddr === ma, {"R3 maddr ", ph}, bus_maddr, ma);
    chk(bus_rd === !wr, {"R4 rd flag ", ph}, bus_rd, !wr);
    chk(bus_wdata === wd, {"R4 wdata ", ph}, bus_wdata, wd);
  endtask

  task automatic access(input bit io, input bit wr, input bit fe,
                        input logic [15:0] ma, input logic [7:0] bk,
                        input logic [2:0] ix, input logic [15:0] wd,
                        input logic [15:0] rdv, input int wait_n);
    @(negedge clk);
    core_valid = 1; core_io = io; core_write = wr; core_fetch = fe;
    core_maddr = ma; core_bank = bk; core_idx = ix; core_wdata = wd;
    @(negedge clk);
    chk_bus(io, wr, fe, ma, bk, ix, wd, "accept");
    // R9: a different request while busy; R10: stray done on the other line
    core_io = !io; core_write = !wr; core_fetch = !fe;
    core_maddr = ~ma; core_bank = ~bk; core_idx = ~ix; core_wdata = ~wd;
    if (io) mem_done = 1; else io_done = 1;
    repeat (wait_n + 3) @(negedge clk);
    chk_bus(io, wr, fe, ma, bk, ix, wd, "R5 R9 R10 waiting");
    core_valid = 0;
    mem_done = 0; io_done = 0;
    @(negedge clk);
    bus_rdata = rdv;
    if (io) io_done = 1; else mem_done = 1;
    repeat (2) @(negedge clk);
    chk((io ? io_req : mem_req) === 1'b1, "R5 req before sync done", io ? io_req : mem_req, 1);
    chk(cmpl === 1'b0, "R6 no early cmpl", cmpl, 0);
    @(negedge clk);
    if (!wr) exp_rd = rdv;
    chk(rd_data === exp_rd, wr ? "R7 write keeps rd_data" : "R6 read captured", rd_data, exp_rd);
    chk(cmpl === 1'b1, "R6 cmpl pulse", cmpl, 1);
    chk(!mem_req && !io_req, "R6 req falls", {io_req, mem_req}, 0);
    bus_rdata = ~rdv;
    @(negedge clk);
    chk(cmpl === 1'b0, "R6 cmpl one cycle", cmpl, 0);
    chk(busy === 1'b1 && !mem_req && !io_req, "R8 busy while done high", {busy, io_req, mem_req}, 3'b100);
    chk(rd_data === exp_rd, "R6 hold after capture", rd_data, exp_rd);
    if (io) io_done = 0; else mem_done = 0;
    repeat (2) @(negedge clk);
    chk(busy === 1'b1 && !mem_req && !io_req, "R8 busy through release", {busy, io_req, mem_req}, 3'b100);
    @(negedge clk);
    chk(busy === 1'b0 && bus_idle === 1'b1, "R8 idle after release", {busy, bus_idle}, 2'b01);
    chk(!mem_req && !io_req, "R9 no new access started", {io_req, mem_req}, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    chk(busy === 0 && mem_req === 0 && io_req === 0 && bus_idle === 1,
        "R1 in reset", {busy, mem_req, io_req, bus_idle}, 4'b0001);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 0 && mem_req === 0 && io_req === 0 && bus_idle === 1,
        "R1 after reset ctrl", {busy, mem_req, io_req, bus_idle}, 4'b0001);
    chk(bus_rd === 1 && bus_fetch === 0 && rd_data === 0,
        "R1 after reset regs", {bus_rd, bus_fetch, rd_data}, 18'h20000);
    for (int k = 0; k < 6; k++) begin
      for (int ix = 0; ix < 8; ix++) begin
        for (int wr = 0; wr < 2; wr++) begin
          logic [7:0] bk;
          logic [15:0] wd, rv;
          bk = 8'((k * 8'h33) & 8'hFF);
          wd = 16'(k * 16'h1357 + ix * 16'h0101 + wr);
          rv = 16'({bk, 5'(ix), 3'(k)} ^ 16'hC3A5);
          access(1'b1, wr[0], 1'b0, 16'h0, bk, 3'(ix), wd, rv, (ix + k) % 4);
        end
      end
    end
    for (int k = 0; k < 24; k++) begin
      logic [15:0] ma, wd, rv;
      bit wr, fe;
      ma = 16'((k * 16'h2F1) ^ 16'hA5A5);
      wd = 16'(k * 16'h0F0F);
      rv = ~ma + 16'(k);
      wr = (k % 3 == 1);
      fe = (k % 3 == 0);
      access(1'b0, wr, fe, ma, 8'h0, 3'h0, wd, rv, (k == 5) ? 60 : k % 5);
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule